// File: doc/BRIEF.md
# Register-Mapped Serial Master with Word Queues

This block is a bus-programmed synchronous serial master. Software pushes words into an eight-entry transmit queue and pops received words from an eight-entry receive queue, all through one data register. While the port is on, an engine takes one word at a time from the transmit queue and shifts it out most significant bit first. It drives a divided serial clock that idles low, with data launched on the falling edge and sampled on the rising edge (mode 0). The word it samples back goes into the receive queue. A loopback setting skips the serial lines and copies each transmitted word straight into the receive queue.

The frame width runs from 1 to 16 bits and is chosen at run time. Every word entering either queue is cut to that width. The engine never overruns the receive side: it will not begin a frame while the receive queue is full. The state of both queues is reported as status flags. Two level interrupt sources, receive at least half full and transmit at most half full, are combined through a mask onto one interrupt line. An eight-byte identification window is readable at the top of the register space.

Top module: `serial_master_regs`

## Requirements
- R1: The transmit and receive queues each hold 8 words. A data write (offset 0x08) made while the transmit queue already holds 8 words is discarded.
- R2: The frame width is the size field (offset 0x00, bits 3:0) plus one. Each word pushed into either queue is ANDed with a mask of that many low ones. The size register reads back its 4-bit field.
- R3: With control (offset 0x04) bit 0 (loopback) and bit 1 (enable) both set, each transmit word moves to the receive queue in one clock while the serial clock, select and data-out lines stay idle.
- R4: With control bit 1 clear, no frame starts and no loopback copy happens, so queued transmit words stay put. Control reads back bits 2:0.
- R5: Status (offset 0x0C) bit 0 = transmit empty, bit 1 = transmit not full, bit 2 = receive not empty, bit 3 = receive full, bit 4 = busy.
- R6: Raw interrupt status (offset 0x18) bit 2 is high when the receive queue holds 4 or more words, and bit 3 is high when the transmit queue holds 4 or fewer words. All other bits are 0.
- R7: The interrupt line is high exactly when raw status ANDed with the mask register (offset 0x14, bits 3:0) is non-zero. Offset 0x1C returns that AND.
- R8: A frame or loopback copy starts only when the receive queue holds fewer than 8 words. Transmission then stalls until software pops a word.
- R9: After reset, status reads 0x03, raw status reads 0x08, the interrupt line is low and all registers are 0.
- R10: Offset 0x10 holds an 8-bit prescaler. Offsets 0xFE0 to 0xFFC return the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word address in that order.
- R11: Reading offset 0x08 returns the oldest receive word, and the pop happens when bus_rd is high. On an empty queue the read returns 0 and changes nothing.
- R12: Each serial clock half period lasts max(prescaler, 2) + 1 clocks. Select is low for the whole frame, data leaves MSB first, and data-in is sampled on each rising serial clock edge.
- R13: Busy is high while a frame is shifting or the transmit queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe; pops the receive queue when addressing data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select, low during a frame |

## Verification
Two pairs of actions can hit the same clock. A software data write can land in the cycle where the engine takes the head of the transmit queue. A software pop of the receive queue can land in the cycle where the engine pushes a finished frame or a loopback copy. The streaming phase provokes both by interleaving data writes and reads at varying gaps against frames in flight, and the loopback and stall phases fill the receive queue to its limit. A behavioural model built on queues is stepped on every clock, and its queue contents, status, interrupt and serial lines are compared with the design each cycle, so a lost or doubled word shows up at once.

// File: rtl/spim_pkg.sv
// Shared constants for the serial master: register offsets, bit positions
// of control/status/interrupt fields and the identification byte table.
package spim_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_SIZE  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_PSC   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_MSKD  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_IDWIN = 12'hFE0;

    localparam int CTL_LOOP = 0;
    localparam int CTL_EN   = 1;
    localparam int CTL_SEL  = 2;
    localparam int CTL_W    = 3;

    localparam int ST_TXE  = 0;
    localparam int ST_TXNF = 1;
    localparam int ST_RXNE = 2;
    localparam int ST_RXF  = 3;
    localparam int ST_BSY  = 4;
    localparam int ST_W    = 5;

    localparam int IRQ_RX = 2;
    localparam int IRQ_TX = 3;
    localparam int IRQ_W  = 4;

    // Identification byte for word index 0..7 of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h22;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/spim_fifo.sv
// Synchronous word queue with occupancy count.
// Assumes the caller never pushes when full nor pops when empty;
// a push and a pop may share a cycle.
module spim_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    store [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the pushed word into its slot.
    always_ff @(posedge clk) begin
        if (push) store[wptr] <= push_data;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    assign head  = store[rptr];
    assign count = cnt;
    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt != CNT_W'(DEPTH)));
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
endmodule

// File: rtl/spim_engine.sv
// Mode-0 shift engine: takes one word when allowed, shifts it out MSB first
// on falling serial clock edges, samples data-in on rising edges and
// presents the received word for one cycle at the end of the frame.
// Assumes size_field is held stable while a frame runs.
module spim_engine #(
    parameter int DW = 16,
    parameter int FW = 4,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_ok,
    input  logic          tx_avail,
    input  logic          rx_room,
    input  logic [DW-1:0] tx_word,
    input  logic [FW-1:0] size_field,
    input  logic [PW-1:0] psc,
    input  logic          miso,
    output logic          take,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic          cs_n
);
    localparam int BW = $clog2(DW + 1);

    logic          busy_q, sclk_q;
    logic [PW-1:0] hcnt, half_lim;
    logic [BW-1:0] bits_left, width_bits;
    logic [DW-1:0] sh_tx, sh_rx;
    logic          tick;

    // Half-period limit with a floor of two.
    always_comb half_lim = (psc < PW'(2)) ? PW'(2) : psc;
    always_comb width_bits = BW'(size_field) + 1'b1;

    assign tick    = busy_q && (hcnt == half_lim);
    assign take    = !busy_q && run_ok && tx_avail && rx_room;
    assign rx_push = tick && sclk_q && (bits_left == BW'(1));
    assign rx_word = sh_rx;

    // Frame sequencing: load, toggle clock, shift, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            sclk_q    <= 1'b0;
            hcnt      <= '0;
            bits_left <= '0;
            sh_tx     <= '0;
            sh_rx     <= '0;
        end else if (take) begin
            busy_q    <= 1'b1;
            sclk_q    <= 1'b0;
            hcnt      <= '0;
            bits_left <= width_bits;
            sh_tx     <= tx_word << (BW'(DW) - width_bits);
            sh_rx     <= '0;
        end else if (busy_q) begin
            if (tick) begin
                hcnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    sh_rx  <= {sh_rx[DW-2:0], miso};
                end else begin
                    sclk_q    <= 1'b0;
                    sh_tx     <= {sh_tx[DW-2:0], 1'b0};
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == BW'(1)) busy_q <= 1'b0;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign sclk = sclk_q;
    assign cs_n = !busy_q;
    assign mosi = busy_q && sh_tx[DW-1];

    assert_idle_clock_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);
    assert_start_needs_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ($past(rx_room) && !sclk_q));
endmodule

// File: rtl/serial_master_regs.sv
// Register-mapped serial master: register file, two word queues, loopback
// path, status and interrupt logic around the shift engine.
// Assumes one bus access per clock; reads are combinational and a data
// read with bus_rd high pops the receive queue at the clock edge.
module serial_master_regs
    import spim_pkg::*;
#(
    parameter int DW    = 16,
    parameter int FW    = 4,
    parameter int PW    = 8,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HALF  = DEPTH / 2;

    logic [FW-1:0]    size_q;
    logic [CTL_W-1:0] ctrl_q;
    logic [PW-1:0]    psc_q;
    logic [IRQ_W-1:0] imask_q;
    logic [DW-1:0]    wmask;

    logic             tx_push, tx_pop, tx_empty, tx_full;
    logic [DW-1:0]    tx_head;
    logic [CNT_W-1:0] tx_cnt;
    logic             rx_push, rx_pop, rx_empty, rx_full;
    logic [DW-1:0]    rx_head, rx_din;
    logic [CNT_W-1:0] rx_cnt;

    logic             eng_take, eng_push, eng_busy, lb_fire;
    logic [DW-1:0]    eng_word;
    logic [ST_W-1:0]  status;
    logic [IRQ_W-1:0] raw;

    // Width mask derived from the size field.
    always_comb wmask = DW'((32'd1 << (32'(size_q) + 32'd1)) - 32'd1);

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= '0;
            ctrl_q  <= '0;
            psc_q   <= '0;
            imask_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_SIZE:  size_q  <= bus_wdata[FW-1:0];
                OFS_CTRL:  ctrl_q  <= bus_wdata[CTL_W-1:0];
                OFS_PSC:   psc_q   <= bus_wdata[PW-1:0];
                OFS_IMASK: imask_q <= bus_wdata[IRQ_W-1:0];
                default: ;
            endcase
        end
    end

    // Queue control: bus pushes/pops, engine and loopback transfers.
    always_comb begin
        tx_push = bus_wr && (bus_addr == OFS_DATA) && !tx_full;
        rx_pop  = bus_rd && (bus_addr == OFS_DATA) && !rx_empty;
        lb_fire = ctrl_q[CTL_EN] && ctrl_q[CTL_LOOP] && !eng_busy && !tx_empty && !rx_full;
        tx_pop  = eng_take || lb_fire;
        rx_push = eng_push || lb_fire;
        rx_din  = (lb_fire ? tx_head : eng_word) & wmask;
    end

    spim_fifo #(.DW(DW), .DEPTH(DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(bus_wdata & wmask),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.DW(DW), .DEPTH(DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_din),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    spim_engine #(.DW(DW), .FW(FW), .PW(PW)) i_eng (
        .clk(clk), .rst_n(rst_n),
        .run_ok(ctrl_q[CTL_EN] && !ctrl_q[CTL_LOOP]),
        .tx_avail(!tx_empty), .rx_room(!rx_full), .tx_word(tx_head),
        .size_field(size_q), .psc(psc_q), .miso(miso),
        .take(eng_take), .rx_push(eng_push), .rx_word(eng_word), .busy(eng_busy),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    // Status flags and level interrupt sources.
    always_comb begin
        status          = '0;
        status[ST_TXE]  = tx_empty;
        status[ST_TXNF] = !tx_full;
        status[ST_RXNE] = !rx_empty;
        status[ST_RXF]  = rx_full;
        status[ST_BSY]  = eng_busy || !tx_empty;
        raw             = '0;
        raw[IRQ_RX]     = (rx_cnt >= CNT_W'(HALF));
        raw[IRQ_TX]     = (tx_cnt <= CNT_W'(HALF));
    end

    assign irq = |(raw & imask_q);

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr >= OFS_IDWIN) begin
            bus_rdata = DW'(id_byte(bus_addr[4:2]));
        end else begin
            case (bus_addr)
                OFS_SIZE:  bus_rdata = DW'(size_q);
                OFS_CTRL:  bus_rdata = DW'(ctrl_q);
                OFS_DATA:  bus_rdata = rx_empty ? '0 : rx_head;
                OFS_STAT:  bus_rdata = DW'(status);
                OFS_PSC:   bus_rdata = DW'(psc_q);
                OFS_IMASK: bus_rdata = DW'(imask_q);
                OFS_RAW:   bus_rdata = DW'(raw);
                OFS_MSKD:  bus_rdata = DW'(raw & imask_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_disabled_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTL_EN] && !eng_busy) |-> (!tx_pop && !rx_push));
    assert_irq_on_rx_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_cnt >= CNT_W'(HALF)) && imask_q[IRQ_RX]) |-> irq);
    assert_loop_lines_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lb_fire |-> (cs_n && !sclk));
endmodule

// File: tb/test_serial_master_regs.sv
module test_serial_master_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] b_addr = '0;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [15:0] b_wdata = '0;
    logic [15:0] rdata;
    logic        irq, sclk, mosi, miso, cs_n;

    int n_chk = 0, n_fail = 0;
    string phase = "R9 reset";
    logic [11:0] idle_addr = 12'h00C;
    bit checking = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign miso = ~mosi;

    serial_master_regs i_serial_master_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .irq(irq), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // ---------------- behavioural reference model ----------------
    int txq[$], rxq[$];
    int m_size, m_ctrl, m_psc, m_imask;
    int m_busy, m_hc, m_bits, m_sclk, m_word, m_acc;

    function automatic int m_mask(); return (1 << (m_size + 1)) - 1; endfunction
    function automatic int m_mosi();
        return m_busy ? ((m_word >> (m_bits - 1)) & 1) : 0;
    endfunction
    function automatic int m_status();
        return ((txq.size() == 0) ? 1 : 0) | ((txq.size() != 8) ? 2 : 0) |
               ((rxq.size() != 0) ? 4 : 0) | ((rxq.size() == 8) ? 8 : 0) |
               ((m_busy != 0 || txq.size() != 0) ? 16 : 0);
    endfunction
    function automatic int m_raw();
        return ((rxq.size() >= 4) ? 4 : 0) | ((txq.size() <= 4) ? 8 : 0);
    endfunction
    function automatic int m_read(input int a);
        if (a >= 'hFE0) begin
            case ((a >> 2) & 7)
                0: return 'h22; 1: return 'h10; 2: return 'h04; 3: return 'h00;
                4: return 'h0D; 5: return 'hF0; 6: return 'h05; default: return 'hB1;
            endcase
        end
        case (a)
            'h00: return m_size;
            'h04: return m_ctrl;
            'h08: return (rxq.size() > 0) ? rxq[0] : 0;
            'h0C: return m_status();
            'h10: return m_psc;
            'h14: return m_imask;
            'h18: return m_raw();
            'h1C: return m_raw() & m_imask;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_size = 0; m_ctrl = 0; m_psc = 0; m_imask = 0;
            m_busy = 0; m_hc = 0; m_bits = 0; m_sclk = 0; m_word = 0; m_acc = 0;
        end else begin
            int tx_n, rx_n, lim, msk, rxp, rxd, w;
            bit push_tx, pop_rx, en, lp;
            tx_n = txq.size(); rx_n = rxq.size();
            msk = m_mask();
            lim = (m_psc < 2) ? 2 : m_psc;
            en = m_ctrl[1]; lp = m_ctrl[0];
            push_tx = b_wr && (b_addr == 12'h008) && (tx_n < 8);
            pop_rx  = b_rd && (b_addr == 12'h008) && (rx_n > 0);
            rxp = 0; rxd = 0;
            if (m_busy != 0) begin
                if (m_hc == lim) begin
                    m_hc = 0;
                    if (m_sclk == 0) begin
                        m_acc = (m_acc << 1) | (1 - m_mosi());
                        m_sclk = 1;
                    end else begin
                        m_sclk = 0;
                        m_bits = m_bits - 1;
                        if (m_bits == 0) begin
                            m_busy = 0; rxp = 1; rxd = m_acc & msk;
                        end
                    end
                end else m_hc = m_hc + 1;
            end else if (en && tx_n > 0 && rx_n < 8) begin
                w = txq.pop_front();
                if (lp) begin
                    rxp = 1; rxd = w & msk;
                end else begin
                    m_busy = 1; m_hc = 0; m_sclk = 0; m_bits = m_size + 1;
                    m_word = w; m_acc = 0;
                end
            end
            if (pop_rx) void'(rxq.pop_front());
            if (rxp != 0) rxq.push_back(rxd);
            if (push_tx) txq.push_back(int'(b_wdata) & msk);
            if (b_wr) begin
                case (b_addr)
                    12'h000: m_size  = int'(b_wdata) & 'hF;
                    12'h004: m_ctrl  = int'(b_wdata) & 'h7;
                    12'h010: m_psc   = int'(b_wdata) & 'hFF;
                    12'h014: m_imask = int'(b_wdata) & 'hF;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    function automatic string addr_tag(input logic [11:0] a);
        if (a >= 12'hFE0) return "R10 id";
        case (a)
            12'h000: return "R2 size";
            12'h004: return "R4 control";
            12'h008: return "R11 data";
            12'h00C: return "R5 status";
            12'h010: return "R10 prescaler";
            12'h014: return "R7 mask";
            12'h018: return "R6 raw";
            12'h01C: return "R7 masked";
            default: return "unmapped";
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input int exp, input string what);
        n_chk++;
        if ($isunknown(act) || int'(act) != exp) begin
            n_fail++;
            $display("FAIL [%s] %s: actual %h expected %h at %0t", phase, what, act, exp[15:0], $time);
        end
    endtask

    task automatic compare();
        if (!checking) return;
        chk(rdata, m_read(int'(b_addr)), addr_tag(b_addr));
        chk({15'd0, sclk}, m_sclk, "R12 sclk");
        chk({15'd0, cs_n}, (m_busy != 0) ? 0 : 1, "R12 cs_n");
        chk({15'd0, mosi}, m_mosi(), "R12 mosi");
        chk({15'd0, irq}, ((m_raw() & m_imask) != 0) ? 1 : 0, "R7 irq");
    endtask

    task automatic step(input logic [11:0] a, input logic w, input logic r, input logic [15:0] d);
        @(negedge clk);
        b_addr = a; b_wr = w; b_rd = r; b_wdata = d;
        #1;
        compare();
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(idle_addr, 1'b0, 1'b0, 16'h0);
    endtask
    task automatic wr(input logic [11:0] a, input logic [15:0] d); step(a, 1'b1, 1'b0, d); endtask
    task automatic rd(input logic [11:0] a); step(a, 1'b0, 1'b1, 16'h0); endtask

    task automatic run_all();
        repeat (3) @(posedge clk);
        checking = 1;
        phase = "R9 reset";
        idle(3);
        idle_addr = 12'h018; idle(2);
        step(12'h000, 0, 0, 0); step(12'h004, 0, 0, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        phase = "R10 prescaler id";
        wr(12'h010, 16'h01AB);
        step(12'h010, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(12'hFE0 + 12'(4 * i), 0, 0, 0);
        wr(12'h010, 16'h0000);

        phase = "R1 R2 R4 R5 R6 fill";
        wr(12'h000, 16'h0007);
        step(12'h000, 0, 0, 0);
        idle_addr = 12'h018;
        for (int i = 0; i < 10; i++) wr(12'h008, 16'h01A5 + 16'(i * 'h111));
        idle(20);
        step(12'h00C, 0, 0, 0);

        phase = "R3 R8 loopback";
        wr(12'h004, 16'h0003);
        idle_addr = 12'h00C;
        idle(12);
        wr(12'h008, 16'h005A); wr(12'h008, 16'h0F0F);
        idle(5);

        phase = "R8 R13 stall";
        wr(12'h004, 16'h0002);
        idle(20);
        rd(12'h008);
        idle(60);

        phase = "R11 drain";
        for (int i = 0; i < 9; i++) rd(12'h008);
        idle(60);
        rd(12'h008); rd(12'h008);

        phase = "R12 R13 stream";
        for (int i = 0; i < 12; i++) begin
            wr(12'h008, 16'h003C + 16'(i * 37));
            idle((i % 5) * 7);
            if (i % 2 == 1) rd(12'h008);
        end
        idle(500);
        for (int i = 0; i < 8; i++) rd(12'h008);

        phase = "R2 R12 width4";
        wr(12'h000, 16'h0003); wr(12'h010, 16'h0005);
        wr(12'h008, 16'hABCD);
        idle(60);
        rd(12'h008);

        phase = "R2 R12 width16";
        wr(12'h000, 16'h000F); wr(12'h010, 16'h0002);
        wr(12'h008, 16'h8001); wr(12'h008, 16'h7FFE);
        idle(250);
        rd(12'h008); rd(12'h008); rd(12'h008);

        phase = "R6 R7 irq";
        wr(12'h014, 16'h0008); idle(3);
        step(12'h01C, 0, 0, 0);
        wr(12'h014, 16'h0004); idle(3);
        wr(12'h004, 16'h0003);
        for (int i = 0; i < 5; i++) wr(12'h008, 16'h1230 + 16'(i));
        idle(8);
        step(12'h01C, 0, 0, 0); step(12'h018, 0, 0, 0);
        for (int i = 0; i < 6; i++) rd(12'h008);
        wr(12'h014, 16'h000C); idle(3);
        wr(12'h014, 16'h0000); idle(3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WD_CYCLES) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: run did not finish, all requirements unverified");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule